// File: doc/BRIEF.md
# Buffered Synchronous Serial Master

This block is a master-only, full-duplex, three-wire serial port. An 8-bit shift register sits between two byte buffers. A write to the data register fills the transmit buffer. A read of the data register returns the receive buffer. The port loads the transmit buffer into the shift register by itself. When software refills the buffer before the current byte ends, the next byte follows with no idle time on the line.

The shift clock comes from a timer tick input, which is a one-cycle enable on the system clock. The serial clock toggles once per tick, so it runs at half the tick rate with an exact 50% duty cycle. Three status events are recorded in a flag register: receive buffer full, transmit buffer empty and transmission complete. Each event drives its own interrupt output when the matching bit of a mask register is set.

Register map on the local bus (`bus_addr`): 0 is data, 1 is status, 2 is mask, and 3 reads as zero. The status and mask registers use bit 0 for receive-full, bit 1 for transmit-empty and bit 2 for transmit-complete.

Top module: `sync_serial_master`

## Requirements
- R1: `sclk` toggles only in cycles that follow a `timer_tick` pulse. While a transfer runs, each high and each low half period is exactly one tick interval. `sclk` stays low while no transfer is active.
- R2: Each frame is 8 bits, most significant bit first. `so` changes only while `sclk` is low (on a falling edge or at a load), and `si` is sampled on each rising edge.
- R3: Transfer is full duplex. The 8 bits sampled on `si` during a frame are placed in the receive buffer at the end of that frame.
- R4: A write to address 0 goes to the transmit buffer. A read of address 0 returns the receive buffer.
- R5: If the transmit buffer is written before the last falling edge of a frame, the next frame starts with no gap. The low time before its first rising edge is one tick interval.
- R6: Status bit 1 (transmit-empty) is set every time the transmit buffer is loaded into the shift register.
- R7: Status bit 2 (transmit-complete) is set only when the last bit of a frame has shifted out and the transmit buffer is empty. It is not set between bytes of a stream.
- R8: Status bit 0 (receive-full) is set when a frame is captured. A read of address 0 clears it. A byte received while the flag is still set overwrites the old byte.
- R9: Writing a 1 to a bit of the status register (address 1) clears that flag. Writing a 0 leaves the flag unchanged.
- R10: The mask register (address 2) uses the same bit positions as the status register. `irq_rxf`, `irq_txe` and `irq_txc` are each high only while their flag and their mask bit are both set.
- R11: After reset, all flags and mask bits are 0, `sclk`, `so` and all interrupt outputs are low, and the transmit buffer is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_tick | input | 1 | One-cycle timer enable; one serial half period per pulse |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 mask |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a data read clears receive-full) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| sclk | output | 1 | Serial clock, driven by the master |
| so | output | 1 | Serial data out |
| si | input | 1 | Serial data in |
| irq_rxf | output | 1 | Receive-full interrupt |
| irq_txe | output | 1 | Transmit-empty interrupt |
| irq_txc | output | 1 | Transmit-complete interrupt |

## Verification
The hardest case to reach from the ports is the reload at the end of a frame. The second byte has to be in the transmit buffer before the eighth falling edge, and the first received byte must stay unread. This is what shows the gapless restart, the missing transmit-complete event between bytes, and the overwrite of the unread byte all at once. The stimulus gets there by writing the second byte right after the first one loads. A bench-side slave model then tracks every `sclk` edge. It records the low time before the ninth rising edge, and it feeds a different byte on `si` for each frame.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
    localparam int FRAME_W = 8;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam int ADDR_W  = 2;

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [CNT_W-1:0]   bitcnt_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_STAT = 2'd1,
        REG_MASK = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // bit 2: transmit complete, bit 1: transmit empty, bit 0: receive full
    typedef struct packed {
        logic txc;
        logic txe;
        logic rxf;
    } ev_t;

    localparam int EV_W = $bits(ev_t);

    function automatic frame_t shift_in(frame_t cur, logic b);
        return {cur[FRAME_W-2:0], b};
    endfunction

    function automatic frame_t ev_to_frame(ev_t e);
        frame_t f;
        f = '0;
        f[EV_W-1:0] = e;
        return f;
    endfunction
endpackage

// File: rtl/ssm_sclk.sv
module ssm_sclk (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    logic sclk_q;

    assign rise_o = run_i & tick_i & ~sclk_q;
    assign fall_o = run_i & tick_i &  sclk_q;
    assign sclk_o = sclk_q;

    always_ff @(posedge clk) begin
        if (rst)         sclk_q <= 1'b0;
        else if (!run_i) sclk_q <= 1'b0;
        else if (tick_i) sclk_q <= ~sclk_q;
    end

    // R1
    sclk_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk_o != $past(sclk_o)) |-> $past(tick_i));

    // R1
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!run_i) |-> !sclk_o);
endmodule

// File: rtl/ssm_shift.sv
module ssm_shift
    import ssm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rise_i,
    input  logic   fall_i,
    input  logic   sclk_i,
    input  logic   si_i,
    input  logic   tx_full_i,
    input  frame_t tx_data_i,
    output logic   busy_o,
    output logic   so_o,
    output logic   load_o,
    output logic   done_o,
    output logic   cmpl_o,
    output frame_t rx_byte_o
);
    frame_t  sr_q;
    bitcnt_t cnt_q;
    logic    busy_q;
    logic    samp_q;
    logic    last_fall;

    assign last_fall = fall_i && (cnt_q == bitcnt_t'(FRAME_W - 1));
    assign load_o    = tx_full_i && (!busy_q || last_fall);
    assign done_o    = last_fall;
    assign cmpl_o    = last_fall && !tx_full_i;
    assign rx_byte_o = shift_in(sr_q, samp_q);
    assign busy_o    = busy_q;
    assign so_o      = busy_q & sr_q[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            samp_q <= 1'b0;
        end else begin
            if (rise_i) samp_q <= si_i;
            if (load_o) begin
                sr_q   <= tx_data_i;
                cnt_q  <= '0;
                busy_q <= 1'b1;
            end else if (fall_i) begin
                sr_q  <= shift_in(sr_q, samp_q);
                cnt_q <= cnt_q + 1'b1;
                if (last_fall) busy_q <= 1'b0;
            end
        end
    end

    // R2
    so_rise_stable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_i) |-> $stable(so_o));

    // R2
    so_high_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sclk_i) && sclk_i) |-> $stable(so_o));
endmodule

// File: rtl/ssm_flags.sv
module ssm_flags
    import ssm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ev_t  set_i,
    input  ev_t  clr_i,
    input  logic mask_wr_i,
    input  ev_t  mask_d_i,
    output ev_t  flags_o,
    output ev_t  mask_o,
    output ev_t  irq_o
);
    ev_t flags_q;
    ev_t mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            mask_q  <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_i) | set_i;
            if (mask_wr_i) mask_q <= mask_d_i;
        end
    end

    assign flags_o = flags_q;
    assign mask_o  = mask_q;
    assign irq_o   = flags_q & mask_q;

    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq_o & ~mask_o) == '0));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        $past(set_i.rxf) |-> flags_o.rxf);
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
    import ssm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                timer_tick,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [FRAME_W-1:0]  bus_wdata,
    output logic [FRAME_W-1:0]  bus_rdata,
    output logic                sclk,
    output logic                so,
    input  logic                si,
    output logic                irq_rxf,
    output logic                irq_txe,
    output logic                irq_txc
);
    reg_sel_e sel;
    frame_t   tx_buf_q, rx_buf_q, rx_byte;
    logic     tx_full_q;
    logic     busy, rise, fall, load, done, cmpl;
    ev_t      set_ev, clr_ev, flags, mask, irq;

    assign sel = reg_sel_e'(bus_addr);

    ssm_sclk u_sclk (
        .clk(clk), .rst(rst), .tick_i(timer_tick), .run_i(busy),
        .sclk_o(sclk), .rise_o(rise), .fall_o(fall)
    );

    ssm_shift u_shift (
        .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall), .sclk_i(sclk),
        .si_i(si), .tx_full_i(tx_full_q), .tx_data_i(tx_buf_q),
        .busy_o(busy), .so_o(so), .load_o(load), .done_o(done),
        .cmpl_o(cmpl), .rx_byte_o(rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_buf_q  <= '0;
            tx_full_q <= 1'b0;
            rx_buf_q  <= '0;
        end else begin
            if (bus_wr && sel == REG_DATA) begin
                tx_buf_q  <= bus_wdata;
                tx_full_q <= 1'b1;
            end else if (load) begin
                tx_full_q <= 1'b0;
            end
            if (done) rx_buf_q <= rx_byte;
        end
    end

    always_comb begin
        set_ev     = '0;
        set_ev.rxf = done;
        set_ev.txe = load;
        set_ev.txc = cmpl;
        clr_ev     = '0;
        if (bus_wr && sel == REG_STAT) clr_ev = ev_t'(bus_wdata[EV_W-1:0]);
        if (bus_rd && sel == REG_DATA) clr_ev.rxf = 1'b1;
    end

    ssm_flags u_flags (
        .clk(clk), .rst(rst), .set_i(set_ev), .clr_i(clr_ev),
        .mask_wr_i(bus_wr && sel == REG_MASK),
        .mask_d_i(ev_t'(bus_wdata[EV_W-1:0])),
        .flags_o(flags), .mask_o(mask), .irq_o(irq)
    );

    always_comb begin
        case (sel)
            REG_DATA: bus_rdata = rx_buf_q;
            REG_STAT: bus_rdata = ev_to_frame(flags);
            REG_MASK: bus_rdata = ev_to_frame(mask);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_rxf = irq.rxf;
    assign irq_txe = irq.txe;
    assign irq_txc = irq.txc;

    // R7
    txc_needs_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.txc) |-> !$past(tx_full_q));

    // R6
    txe_on_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> flags.txe);
endmodule

// File: tb/test_sync_serial_master.sv
`timescale 1ns/1ps
module test_sync_serial_master;
    localparam int TICK = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       timer_tick = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sclk, so, irq_rxf, irq_txe, irq_txc;
    logic       si_r = 1'b0;

    int errors = 0, checks = 0;
    bit done_flag = 0;

    logic [7:0] slv [4];
    logic [7:0] mosi_q [4];
    logic [7:0] mbyte;
    int rises, falls, len, hi_bad;
    int lowlen [32];
    logic prev_sclk;

    always #2.5 clk = ~clk;

    sync_serial_master i_sync_serial_master (
        .clk(clk), .rst(rst), .timer_tick(timer_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sclk(sclk), .so(so), .si(si_r),
        .irq_rxf(irq_rxf), .irq_txe(irq_txe), .irq_txc(irq_txc)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        forever begin
            repeat (TICK - 1) @(negedge clk);
            timer_tick = 1'b1;
            @(negedge clk);
            timer_tick = 1'b0;
        end
    end

    // slave model: sees sclk edges at negedge, answers on si
    initial begin
        prev_sclk = 1'b0;
        forever begin
            @(negedge clk);
            if (sclk !== prev_sclk) begin
                if (sclk) begin
                    if (rises < 32) lowlen[rises] = len;
                    mbyte = {mbyte[6:0], so};
                    rises++;
                    if (rises % 8 == 0 && rises / 8 <= 4) mosi_q[rises/8-1] = mbyte;
                end else begin
                    if (len != TICK) hi_bad++;
                    falls++;
                    if (falls / 8 < 4) si_r = slv[falls/8][7 - (falls % 8)];
                end
                len = 1;
            end else begin
                len++;
            end
            prev_sclk = sclk;
        end
    end

    task automatic mon_reset(logic [7:0] b0, logic [7:0] b1);
        slv[0] = b0; slv[1] = b1; slv[2] = 8'h00; slv[3] = 8'h00;
        rises = 0; falls = 0; hi_bad = 0; len = 0; mbyte = 8'h00;
        si_r = b0[7];
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_flag(int b);
        logic [7:0] s;
        int n = 0;
        s = 8'h00;
        while (!s[b] && n < 2000) begin
            peek(2'd1, s);
            n++;
        end
    endtask

    task automatic t_reset();
        logic [7:0] s;
        peek(2'd1, s);
        check("R11 status", s, 8'h00);
        peek(2'd2, s);
        check("R11 mask", s, 8'h00);
        check("R11 sclk/so/irq", {sclk, so, irq_rxf, irq_txe, irq_txc}, 0);
    endtask

    task automatic t_single();
        logic [7:0] s, d;
        mon_reset(8'h3C, 8'h00);
        bus_write(2'd0, 8'hA5);
        wait_flag(2);
        repeat (2) @(negedge clk);
        check("R2 mosi byte", mosi_q[0], 8'hA5);
        check("R1 high halves", hi_bad, 0);
        check("R1 edge count", rises, 8);
        peek(2'd1, s);
        check("R6 R7 R8 status", s, 8'h07);
        check("R10 irq masked off", {irq_rxf, irq_txe, irq_txc}, 0);
        bus_read(2'd0, d);
        check("R3 R4 rx byte", d, 8'h3C);
        peek(2'd1, s);
        check("R8 read clears rxf", s, 8'h06);
        bus_write(2'd1, 8'h00);
        peek(2'd1, s);
        check("R9 zero write no effect", s, 8'h06);
        bus_write(2'd1, 8'h06);
        peek(2'd1, s);
        check("R9 w1c", s, 8'h00);
        check("R1 idle low", {sclk, so}, 0);
    endtask

    task automatic t_mask();
        logic [7:0] s;
        bus_write(2'd2, 8'h05);
        peek(2'd2, s);
        check("R10 mask readback", s, 8'h05);
        mon_reset(8'hF0, 8'h00);
        bus_write(2'd0, 8'h0F);
        wait_flag(2);
        @(negedge clk);
        check("R10 irq rxf,txe,txc", {irq_rxf, irq_txe, irq_txc}, 3'b101);
        bus_write(2'd1, 8'h01);
        @(negedge clk);
        check("R10 irq after clear", {irq_rxf, irq_txe, irq_txc}, 3'b001);
        bus_write(2'd1, 8'h07);
        bus_write(2'd2, 8'h00);
        @(negedge clk);
        check("R10 irq all off", {irq_rxf, irq_txe, irq_txc}, 3'b000);
    endtask

    task automatic t_stream();
        logic [7:0] s, d;
        mon_reset(8'hC3, 8'h5A);
        bus_write(2'd0, 8'h81);
        repeat (2) @(negedge clk);
        bus_write(2'd1, 8'h02);
        bus_write(2'd0, 8'h7E);
        wait_flag(0);
        peek(2'd1, s);
        check("R6 R7 mid-stream status", s, 8'h03);
        wait_flag(2);
        repeat (2) @(negedge clk);
        check("R2 stream byte0", mosi_q[0], 8'h81);
        check("R2 stream byte1", mosi_q[1], 8'h7E);
        check("R5 gapless low time", lowlen[8], TICK);
        check("R1 stream high halves", hi_bad, 0);
        bus_read(2'd0, d);
        check("R8 overrun overwrites", d, 8'h5A);
        bus_write(2'd1, 8'h07);
        check("R1 idle after stream", {sclk, so}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_mask();
        t_stream();
        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule